// File: doc/BRIEF.md
# Commutation-Synchronized Control Preload

This block keeps the output control fields of a bank of timer channels. Each channel has an enable bit, a complementary-enable bit and a 3-bit output mode. Software writes these fields through a simple register write port into a staging copy. The active copy is what the output stage sees. For channels that have a complementary output, a configuration bit picks one of two behaviours. In direct mode, a write reaches the active copy at once. In staged mode, the active copy changes only when a commutation event occurs.

A second configuration bit picks the event source. With this bit at 0, only a software generate strobe is an event. With it at 1, a rising edge on the trigger input is also an event. Every event sets a sticky flag. Software clears the flag by writing 1 to it.

The block is used to switch the drive pattern of several complementary channels in a single clock cycle, for example in motor commutation. Software stages the next pattern at any time. The switch then happens on the chosen event.

Top module: `ccp_comm_preload`

## Requirements
- R1: With the staged-mode bit (config address 0, bit 0) at 0, a write to a channel address replaces that channel's active fields at the clock edge that accepts the write, so the new value is visible one cycle after the write is presented.
- R2: With the staged-mode bit at 1, a write to a complementary channel leaves its active fields unchanged. The written value is copied into the active fields at the next commutation event.
- R3: With the event-source bit (config address 0, bit 1) at 0, the only commutation event is a write of 1 to bit 0 of generate address 2. Trigger input activity causes no event.
- R4: With the event-source bit at 1, a commutation event is either a generate strobe or a rising trigger edge. A rising edge means the trigger is high in a cycle after it was low in the previous cycle. A trigger held high, or a falling trigger, causes no event.
- R5: Channels with index NUM_CMP and above have no complementary output. They always update directly, whatever the staged-mode bit is, and their complementary-enable bit always reads 0.
- R6: Each commutation event sets the sticky flag `com_flag` one cycle later. Writing 1 to bit 0 of flag address 1 clears it. Writing 0 there has no effect. If a set and a clear happen in the same cycle, the set wins.
- R7: After reset, every active field and the flag are 0, and both configuration bits are 0.
- R8: If a write to a staged complementary channel and a commutation event happen in the same cycle, the active fields take the newly written value.
- R9: A channel write goes to address 4+c for channel c, with data bit 0 as enable, bit 1 as complementary enable and bits 4:2 as mode. The active bus carries channel c at bits [5c+4:5c] in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| trig_in | input | 1 | Trigger input, synchronous to clk |
| act_ctl | output | 5*NUM_CH | Active control fields of all channels |
| com_flag | output | 1 | Sticky commutation-event flag |

## Verification
The assertions check several rules on every cycle. A staged complementary channel holds while no event occurs. A direct write lands one cycle later. A write wins over an event in the same cycle. A cleared event-source bit blocks every event except the strobe. A rising trigger edge with the source bit set always produces an event. The flag rises after each event. The bench's scenarios are needed to show the end-to-end results. These include a staged value that appears only at the event, a trigger held high that fires just once, mode switches between direct and staged operation with values still pending, and flag clears that race with new events.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef struct packed {
    logic [2:0] mode;
    logic       en_n;
    logic       en;
  } ccp_ctl_t;

  localparam int unsigned CTL_W     = $bits(ccp_ctl_t);
  localparam int unsigned ADR_CFG   = 0;
  localparam int unsigned ADR_FLAG  = 1;
  localparam int unsigned ADR_GEN   = 2;
  localparam int unsigned ADR_CH0   = 4;
  localparam int unsigned CFG_STAGE = 0;
  localparam int unsigned CFG_TSEL  = 1;
endpackage

// File: rtl/ccp_evt_gen.sv
module ccp_evt_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_sel,
  input  logic sw_gen,
  input  logic trig_in,
  output logic evt
);
  logic trig_q;
  logic trig_d;
  logic trig_rise;

  always_comb begin
    trig_d    = trig_in;
    trig_rise = trig_in & ~trig_q;
    evt       = sw_gen | (trig_sel & trig_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  AST_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_sel && !sw_gen) |-> !evt); // R3
  AST_TRIG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel && $rose(trig_in)) |-> evt); // R4
  AST_STRB_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gen |-> evt); // R3
endmodule

// File: rtl/ccp_flag.sv
module ccp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = set | clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6
endmodule

// File: rtl/ccp_chan_slot.sv
module ccp_chan_slot
  import ccp_pkg::*;
#(
  parameter bit HAS_COMP = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stage_mode,
  input  logic     evt,
  input  logic     wr_hit,
  input  ccp_ctl_t wr_field,
  output ccp_ctl_t act
);
  ccp_ctl_t stg_q, stg_d;
  ccp_ctl_t act_q, act_d;
  logic     stg_ce, act_ce;
  ccp_ctl_t field_m;

  always_comb begin
    field_m = wr_field;
    if (!HAS_COMP) field_m.en_n = 1'b0;
  end

  generate
    if (HAS_COMP) begin : g_comp
      always_comb begin
        stg_ce = wr_hit;
        stg_d  = field_m;
        if (!stage_mode) begin
          act_ce = wr_hit;
          act_d  = field_m;
        end else begin
          act_ce = evt;
          act_d  = wr_hit ? field_m : stg_q;
        end
      end

      AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_mode && !evt) |=> $stable(act_q)); // R2
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_mode && evt && wr_hit) |=> (act_q == $past(wr_field))); // R8
      AST_DIRECT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_mode && wr_hit) |=> (act_q == $past(wr_field))); // R1
    end else begin : g_plain
      always_comb begin
        stg_ce = wr_hit;
        stg_d  = field_m;
        act_ce = wr_hit;
        act_d  = field_m;
      end

      AST_PLAIN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (act_q.mode == $past(wr_field.mode)
                    && act_q.en == $past(wr_field.en))); // R5
      AST_NO_COMP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q.en_n); // R5
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (stg_ce) stg_q <= stg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_ce) act_q <= act_d;
  end

  assign act = act_q;
endmodule

// File: rtl/ccp_comm_preload.sv
module ccp_comm_preload
  import ccp_pkg::*;
#(
  parameter int unsigned NUM_CH   = 6,
  parameter int unsigned NUM_CMP  = 3,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      trig_in,
  output logic [NUM_CH*CTL_W-1:0]   act_ctl,
  output logic                      com_flag
);
  localparam int unsigned ACT_W = NUM_CH * CTL_W;

  logic     stage_q, stage_d;
  logic     tsel_q, tsel_d;
  logic     cfg_ce;
  logic     sw_gen;
  logic     flag_clr;
  logic     evt;
  ccp_ctl_t wr_field;

  always_comb begin
    cfg_ce   = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
    stage_d  = wr_data[CFG_STAGE];
    tsel_d   = wr_data[CFG_TSEL];
    sw_gen   = wr_en && (wr_addr == ADDR_W'(ADR_GEN)) && wr_data[0];
    flag_clr = wr_en && (wr_addr == ADDR_W'(ADR_FLAG)) && wr_data[0];
    wr_field = ccp_ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      tsel_q  <= 1'b0;
    end else if (cfg_ce) begin
      stage_q <= stage_d;
      tsel_q  <= tsel_d;
    end
  end

  ccp_evt_gen u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (tsel_q),
    .sw_gen   (sw_gen),
    .trig_in  (trig_in),
    .evt      (evt)
  );

  ccp_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt),
    .clr   (flag_clr),
    .flag  (com_flag)
  );

  logic [ACT_W-1:0] act_bus;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic     hit;
    ccp_ctl_t act_c;
    assign hit = wr_en && (wr_addr == ADDR_W'(ADR_CH0 + c));
    ccp_chan_slot #(.HAS_COMP(c < NUM_CMP)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_mode (stage_q),
      .evt        (evt),
      .wr_hit     (hit),
      .wr_field   (wr_field),
      .act        (act_c)
    );
    assign act_bus[c*CTL_W +: CTL_W] = act_c;
  end

  assign act_ctl = act_bus;

  initial begin
    AST_PARAM_FIT: assert (ADR_CH0 + NUM_CH <= (1 << ADDR_W) && NUM_CMP <= NUM_CH
                           && DATA_W >= CTL_W); // R9
  end
endmodule

// File: tb/test_ccp_comm_preload.sv
module test_ccp_comm_preload;
  localparam int NCH = 6;
  localparam int NCMP = 3;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk, rst_n, wr_en, trig_in;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NCH*5-1:0] act_ctl;
  logic com_flag;

  ccp_comm_preload #(.NUM_CH(NCH), .NUM_CMP(NCMP), .ADDR_W(AW), .DATA_W(DW)) i_ccp_comm_preload (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .act_ctl(act_ctl), .com_flag(com_flag));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic m_stage, m_tsel, m_flag, m_tprev;
  logic [4:0] m_stg [NCH];
  logic [4:0] m_act [NCH];

  function automatic logic [NCH*5-1:0] exp_bus();
    logic [NCH*5-1:0] b;
    for (int c = 0; c < NCH; c++) b[c*5 +: 5] = m_act[c];
    return b;
  endfunction

  function automatic string pick_tag(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic t);
    if (we && a >= 4 && int'(a) - 4 >= NCMP) return "R5";
    if (we && a >= 4) return m_stage ? "R2" : "R1";
    if (we && a == 1) return "R6";
    if (we && a == 2) return "R3";
    if (t && !m_tprev) return m_tsel ? "R4" : "R3";
    return "R9";
  endfunction

  // Reference model step, applied for the edge that takes the current inputs
  task automatic model_step(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic t);
    logic evt;
    logic [4:0] f;
    evt = (we && a == 2 && d[0]) || (m_tsel && t && !m_tprev);
    for (int c = 0; c < NCH; c++) begin
      logic hit;
      hit = we && (int'(a) == 4 + c);
      f = d[4:0];
      if (c >= NCMP) f[1] = 1'b0;
      if (c >= NCMP || !m_stage) begin
        if (hit) m_act[c] = f;
      end else if (evt) begin
        m_act[c] = hit ? f : m_stg[c];
      end
      if (hit) m_stg[c] = f;
    end
    if (evt) m_flag = 1'b1;
    else if (we && a == 1 && d[0]) m_flag = 1'b0;
    if (we && a == 0) begin m_stage = d[0]; m_tsel = d[1]; end
    m_tprev = t;
  endtask

  task automatic check(string tag);
    n_vec++;
    if (act_ctl !== exp_bus()) begin
      n_bad++;
      $display("FAIL %s act_ctl actual=%h expected=%h", tag, act_ctl, exp_bus());
    end
    n_vec++;
    if (com_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s com_flag actual=%b expected=%b", tag, com_flag, m_flag);
    end
  endtask

  // Drive at negedge, let the posedge take it, check at the next negedge
  task automatic cyc(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic t, string tag = "");
    string tg;
    tg = (tag == "") ? pick_tag(we, a, d, t) : tag;
    wr_en = we; wr_addr = a; wr_data = d; trig_in = t;
    @(posedge clk);
    model_step(we, a, d, t);
    @(negedge clk);
    check(tg);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; trig_in = 0;
    m_stage = 0; m_tsel = 0; m_flag = 0; m_tprev = 0;
    for (int c = 0; c < NCH; c++) begin m_stg[c] = '0; m_act[c] = '0; end
    repeat (3) @(negedge clk);
    check("R7");
    rst_n = 1'b1;
    @(negedge clk);
    check("R7");
    // direct mode write
    cyc(1, 4, 8'h1F, 0, "R1");
    cyc(1, 9, 8'h1F, 0, "R5");
    // staged mode, sw strobe only
    cyc(1, 0, 8'h01, 0, "R2");
    cyc(1, 5, 8'h0B, 0, "R2");
    cyc(0, 0, 0, 1, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 2, 8'h01, 0, "R3");
    cyc(1, 2, 8'h00, 0, "R3");
    cyc(1, 1, 8'h00, 0, "R6");
    cyc(1, 1, 8'h01, 0, "R6");
    // trigger source on
    cyc(1, 0, 8'h03, 0, "R4");
    cyc(1, 6, 8'h16, 0, "R2");
    cyc(0, 0, 0, 1, "R4");
    cyc(1, 1, 8'h01, 1, "R4");
    cyc(1, 4, 8'h0C, 1, "R4");
    cyc(0, 0, 0, 0, "R4");
    // write and event in same cycle
    cyc(1, 5, 8'h11, 1, "R8");
    cyc(1, 6, 8'h07, 0, "R8");
    cyc(1, 6, 8'h19, 0, "R8");
    // set and clear race
    cyc(1, 1, 8'h01, 0, "R6");
    cyc(1, 2, 8'h01, 0, "R6");
    cyc(1, 7, 8'h1E, 0, "R5");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      we = ($urandom % 4) != 0;
      a = AW'($urandom % (4 + NCH));
      d = DW'($urandom);
      cyc(we, a, d, ($urandom % 3) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule